// File: doc/BRIEF.md
# Virtual Thread Dispatch Scheduler

This block distributes a range of virtual thread numbers across a fixed pool of worker units after a spawn command. A master controller issues a spawn that carries an inclusive upper thread number. The scheduler captures that limit once and presents it to every unit at the same moment. Each unit's first thread is the one whose number equals the unit's own position in the pool. Units whose position is already above the limit sit out the spawn entirely.

When a unit signals that its current thread has finished, it takes its next thread number from a shared counter with an atomic fetch-and-increment. Several units may finish in the same cycle. In that case they are ranked by unit position, so each one receives a different consecutive value. A claimed number above the limit retires the unit. Once every unit has retired, the scheduler pulses join for one cycle and is ready for the next spawn. Thread bodies are outside the block: a running unit shows its thread number and waits for a done strobe, which may arrive after any latency.

Top module: `thread_dispatch_sched`

## Requirements
- R1: After reset, `busy`, `joinPulse` and every bit of `unitRun` are 0.
- R2: A spawn (`spawnValid` high while `busy` is low) is accepted on the clock edge and `busy` is high in the following cycle. The limit is captured at that edge, so later changes on `spawnBound` have no effect on the running spawn.
- R3: On acceptance, unit i (numbered from 0) starts running with `unitIdx` slice i equal to i if i is at most the limit. Otherwise its `unitRun` bit stays 0 for the whole spawn.
- R4: The shared counter starts at the number of units. Units that have `unitDone` high while running in the same cycle each receive the counter plus the count of lower-numbered units also finishing in that cycle. The counter then advances by the number of finishing units. The new number appears on the next cycle.
- R5: A unit whose claimed number is greater than the limit drops `unitRun` on the next cycle and stays retired until the next spawn.
- R6: Over one spawn, every thread number from 0 to the limit is run to completion exactly once, and no number above the limit is ever shown on a running unit.
- R7: One cycle after the last unit retires, `joinPulse` is high for exactly one cycle and `busy` is low in that same cycle.
- R8: A spawn request while `busy` is high is ignored: the running spawn keeps its limit and its thread assignment.
- R9: While a unit runs and its `unitDone` is low, its `unitRun` stays high and its `unitIdx` slice does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spawnValid | input | 1 | Spawn request from the master controller |
| spawnBound | input | IDX_W | Inclusive highest thread number of the spawn |
| busy | output | 1 | A spawn is in progress |
| joinPulse | output | 1 | One-cycle pulse when all units have retired |
| unitRun | output | NUM_UNITS | Bit i: unit i is running a thread |
| unitIdx | output | NUM_UNITS*IDX_W | Slice i: thread number of unit i |
| unitDone | input | NUM_UNITS | Bit i: unit i has finished its current thread |

## Verification
The bench instantiates the block with 4 units and a 6-bit thread number. This makes the whole range of limits, 0 to 63, reachable in short runs. It covers limits below, equal to and far above the unit count, including the 63 case where the counter must carry past the index width. With only four units, finish strobes at full probability regularly make all units claim in the same cycle, which exercises the rank-ordered claims. Low probabilities spread the claims out. Spawn requests injected mid-run, and limit changes after acceptance, test that the captured limit holds.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;

  // strobes from the control FSM to the unit/counter datapath
  typedef struct packed {
    logic load;     // capture limit, seed counter, assign first threads
    logic claimEn;  // finish strobes may claim from the shared counter
  } schedStrb_t;

endpackage

// File: rtl/thread_sched_ctrl.sv
module thread_sched_ctrl
  import thread_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spawnValid,
  input  logic       allRetired,
  output schedStrb_t strb,
  output logic       busy,
  output logic       joinPulse
);

  logic activeQ;
  logic joinQ;
  logic accept;

  assign accept       = spawnValid & ~activeQ;
  assign strb.load    = accept;
  assign strb.claimEn = activeQ;
  assign busy         = activeQ;
  assign joinPulse    = joinQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeQ <= 1'b0;
      joinQ   <= 1'b0;
    end else begin
      joinQ <= activeQ & allRetired;
      if (accept)
        activeQ <= 1'b1;
      else if (activeQ && allRetired)
        activeQ <= 1'b0;
    end
  end

endmodule

// File: rtl/thread_sched_dp.sv
module thread_sched_dp
  import thread_sched_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = 10,
  parameter int CNT_W     = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  schedStrb_t                 strb,
  input  logic [IDX_W-1:0]           spawnBound,
  input  logic [NUM_UNITS-1:0]       unitDone,
  output logic [NUM_UNITS-1:0]       unitRun,
  output logic [NUM_UNITS*IDX_W-1:0] unitIdx,
  output logic                       allRetired
);

  logic [IDX_W-1:0]     boundQ;
  logic [CNT_W-1:0]     ctrQ;
  logic [NUM_UNITS-1:0] runQ;
  logic [IDX_W-1:0]     idxQ [NUM_UNITS];
  logic [NUM_UNITS-1:0] claim;
  logic [CNT_W-1:0]     rank [NUM_UNITS+1];
  logic [CNT_W-1:0]     claimVal [NUM_UNITS];

  // prefix count of simultaneous claims, lower unit number first
  always_comb begin
    claim   = runQ & unitDone & {NUM_UNITS{strb.claimEn}};
    rank[0] = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      claimVal[i] = ctrQ + rank[i];
      rank[i+1]   = rank[i] + CNT_W'(claim[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boundQ <= '0;
      ctrQ   <= '0;
    end else if (strb.load) begin
      boundQ <= spawnBound;
      ctrQ   <= CNT_W'(NUM_UNITS);
    end else begin
      ctrQ   <= ctrQ + rank[NUM_UNITS];
    end
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gUnit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        runQ[g] <= 1'b0;
        idxQ[g] <= '0;
      end else if (strb.load) begin
        runQ[g] <= (CNT_W'(g) <= CNT_W'(spawnBound));
        idxQ[g] <= IDX_W'(g);
      end else if (claim[g]) begin
        runQ[g] <= (claimVal[g] <= CNT_W'(boundQ));
        idxQ[g] <= claimVal[g][IDX_W-1:0];
      end
    end
    assign unitIdx[g*IDX_W +: IDX_W] = idxQ[g];
  end

  assign unitRun    = runQ;
  assign allRetired = ~|runQ;

endmodule

// File: rtl/thread_dispatch_sched.sv
module thread_dispatch_sched
  import thread_sched_pkg::*;
#(
  parameter int NUM_UNITS = 8,   // must not exceed 2**IDX_W
  parameter int IDX_W     = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spawnValid,
  input  logic [IDX_W-1:0]           spawnBound,
  output logic                       busy,
  output logic                       joinPulse,
  output logic [NUM_UNITS-1:0]       unitRun,
  output logic [NUM_UNITS*IDX_W-1:0] unitIdx,
  input  logic [NUM_UNITS-1:0]       unitDone
);

  localparam int CNT_W = IDX_W + 1;

  schedStrb_t strb;
  logic       allRetired;

  thread_sched_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .spawnValid (spawnValid),
    .allRetired (allRetired),
    .strb       (strb),
    .busy       (busy),
    .joinPulse  (joinPulse)
  );

  thread_sched_dp #(
    .NUM_UNITS (NUM_UNITS),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .spawnBound (spawnBound),
    .unitDone   (unitDone),
    .unitRun    (unitRun),
    .unitIdx    (unitIdx),
    .allRetired (allRetired)
  );

endmodule

// File: rtl/thread_dispatch_sched_chk.sv
module thread_dispatch_sched_chk #(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       spawnValid,
  input logic [IDX_W-1:0]           spawnBound,
  input logic                       busy,
  input logic                       joinPulse,
  input logic [NUM_UNITS-1:0]       unitRun,
  input logic [NUM_UNITS*IDX_W-1:0] unitIdx,
  input logic [NUM_UNITS-1:0]       unitDone
);

  logic [IDX_W-1:0] limSeen;
  logic             dupRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                limSeen <= '0;
    else if (spawnValid && !busy) limSeen <= spawnBound;
  end

  always_comb begin
    dupRun = 1'b0;
    for (int a = 0; a < NUM_UNITS; a++)
      for (int b = a + 1; b < NUM_UNITS; b++)
        if (unitRun[a] && unitRun[b] &&
            unitIdx[a*IDX_W +: IDX_W] == unitIdx[b*IDX_W +: IDX_W])
          dupRun = 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (unitRun == '0));

  assert_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dupRun);

  assert_join_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    joinPulse |=> !joinPulse);

  assert_join_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    joinPulse |-> (unitRun == '0 && !busy));

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gUnitChk
    assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      unitRun[g] |-> (unitIdx[g*IDX_W +: IDX_W] <= limSeen));

    assert_idx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && unitRun[g] && !unitDone[g]) |=>
        (unitRun[g] && $stable(unitIdx[g*IDX_W +: IDX_W])));
  end

endmodule

bind thread_dispatch_sched thread_dispatch_sched_chk #(
  .NUM_UNITS (NUM_UNITS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spawnValid (spawnValid),
  .spawnBound (spawnBound),
  .busy       (busy),
  .joinPulse  (joinPulse),
  .unitRun    (unitRun),
  .unitIdx    (unitIdx),
  .unitDone   (unitDone)
);

// File: tb/thread_dispatch_sched_tb.sv
`timescale 1ns/1ps
module thread_dispatch_sched_tb;

  localparam int NU = 4;
  localparam int IW = 6;
  localparam int NT = 1 << IW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             spawnValid = 1'b0;
  logic [IW-1:0]    spawnBound = '0;
  logic             busy;
  logic             joinPulse;
  logic [NU-1:0]    unitRun;
  logic [NU*IW-1:0] unitIdx;
  logic [NU-1:0]    unitDone = '0;

  int checks = 0;
  int fails  = 0;
  int execCnt [NT];
  int expIdx  [NU];
  logic [NU-1:0] expRun;
  int expCtr;

  always #2.5 clk = ~clk;

  thread_dispatch_sched #(.NUM_UNITS(NU), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .spawnValid(spawnValid), .spawnBound(spawnBound),
    .busy(busy), .joinPulse(joinPulse), .unitRun(unitRun), .unitIdx(unitIdx),
    .unitDone(unitDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int idxOf(input int u);
    return int'(unitIdx[u*IW +: IW]);
  endfunction

  task automatic compareUnits(input string tagIdx);
    for (int u = 0; u < NU; u++) begin
      check(unitRun[u] == expRun[u], "R5 run", int'(unitRun[u]), int'(expRun[u]));
      if (expRun[u]) check(idxOf(u) == expIdx[u], tagIdx, idxOf(u), expIdx[u]);
    end
  endtask

  task automatic runSpawn(input int lim, input int doneProb, input bit tryNest);
    int retWait;
    int bad;
    int total;
    @(negedge clk);
    spawnValid = 1'b1;
    spawnBound = IW'(lim);
    @(negedge clk);
    spawnValid = 1'b0;
    spawnBound = IW'(~lim);   // R2: change after acceptance must not matter
    for (int t = 0; t < NT; t++) execCnt[t] = 0;
    expCtr = NU;
    for (int u = 0; u < NU; u++) begin
      expRun[u] = (u <= lim);
      expIdx[u] = u;
    end
    check(busy == 1'b1, "R2 busy", int'(busy), 1);
    compareUnits("R3 first idx");
    retWait = 0;
    for (int c = 0; c < 20000; c++) begin
      logic [NU-1:0] dv;
      spawnValid = 1'b0;
      if (c > 0) compareUnits("R4 claim idx");
      if (expRun == '0) begin
        retWait++;
        if (retWait == 1) begin
          check(joinPulse == 1'b0, "R7 early join", int'(joinPulse), 0);
          check(busy == 1'b1, "R7 busy before join", int'(busy), 1);
        end else begin
          check(joinPulse == 1'b1, "R7 join", int'(joinPulse), 1);
          check(busy == 1'b0, "R7 busy at join", int'(busy), 0);
          break;
        end
      end else begin
        check(joinPulse == 1'b0, "R7 join while running", int'(joinPulse), 0);
      end
      dv = '0;
      for (int u = 0; u < NU; u++)
        if (expRun[u] && ($urandom % 100) < doneProb) dv[u] = 1'b1;
      if (tryNest && c == 2) begin   // R8: nested spawn attempt
        spawnValid = 1'b1;
        spawnBound = IW'((lim + 9) % NT);
      end
      for (int u = 0; u < NU; u++) begin
        if (dv[u]) begin
          execCnt[expIdx[u]]++;
          if (expCtr > lim) expRun[u] = 1'b0;
          else expIdx[u] = expCtr;
          expCtr++;
        end
      end
      unitDone = dv;
      @(negedge clk);
      unitDone = '0;
    end
    bad = 0;
    total = 0;
    for (int t = 0; t < NT; t++) begin
      total += execCnt[t];
      if (execCnt[t] != ((t <= lim) ? 1 : 0)) bad++;
    end
    check(bad == 0, "R6 coverage", bad, 0);
    check(total == lim + 1, "R8 thread total", total, lim + 1);
    @(negedge clk);
    check(joinPulse == 1'b0, "R7 single pulse", int'(joinPulse), 0);
    check(unitRun == '0, "R5 retired after join", int'(unitRun), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(unitRun == '0, "R1 run", int'(unitRun), 0);
    check(joinPulse == 1'b0, "R1 join", int'(joinPulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after release", int'(busy), 0);
    runSpawn(0, 50, 1'b0);
    runSpawn(1, 100, 1'b0);
    runSpawn(NU - 1, 100, 1'b0);
    runSpawn(NU, 100, 1'b1);
    runSpawn(2, 30, 1'b1);
    runSpawn(NT - 1, 100, 1'b0);
    runSpawn(NT - 1, 25, 1'b1);
    for (int k = 0; k < 10; k++)
      runSpawn(int'($urandom % NT), 20 + int'($urandom % 70), 1'(($urandom % 2)));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule